// File: doc/BRIEF.md
# Vector coprocessor instruction decoder

This block sits beside a host core and handles the coprocessor-2 instructions that the core hands over one at a time. It first checks whether the coprocessor is enabled. It then does one of three things:

- For the four branch-on-busy forms, it resolves whether the branch is taken, computes the target and decides whether the delay slot must be cancelled.
- For control-register and vector-register moves, it issues one request on a simple req/ack bus.
- For every other encoding, it raises a reserved-instruction exception.

The vector unit reports its busy state on one input, which is bit 0 of its status word. A move that carries the interlock bit waits, with the stall output high, until that flag drops. A word read back from the bus goes to the host's register file sign-extended to 64 bits.

Top module: `vcop_decoder`

## Requirements
- R1: After reset, done, bus_req, stall, gpr_we, br_taken, nullify and exc are all low.
- R2: When cop2_en is low, an accepted instruction of any kind produces exc=2'b01 and done for one cycle, with no bus request, no GPR write and no branch.
- R3: Format 5'h08 (bits 25:21) is a branch. The rt field (bits 20:16) selects the condition: 0 takes the branch when not busy, 1 when busy, 2 is the likely form taken when not busy, and 3 is the likely form taken when busy. Any other rt value is reserved.
- R4: The branch target is pc + 4 + (sign-extended bits 15:0 shifted left by 2).
- R5: For the likely forms (rt=2 or 3), nullify is high exactly when the branch is not taken. For rt=0 and rt=1, nullify stays low.
- R6: Formats 5'h02 (read) and 5'h06 (write) are control moves only when bits 10:1 are zero. Their bus address is CTRL_BASE + id*16, where id is bits 15:11. If bits 10:1 are not zero, the encoding is reserved.
- R7: Formats 5'h01 (read) and 5'h05 (write) are vector-register moves. Their bus address is VREG_BASE + id*16.
- R8: When bit 0 (interlock) is set on a move and vu_busy is high, stall stays high and bus_req stays low until vu_busy falls. Without the interlock bit, the request goes out regardless of busy.
- R9: A read move writes rt with the bus word sign-extended to 64 bits, with gpr_we high in the same cycle as done. A write move puts the low 32 bits of gpr_rt_val on bus_wdata, with bus_we high.
- R10: Any other encoding produces exc=2'b10 and done for one cycle, with no bus request and no GPR write.
- R11: Each move issues exactly one bus transaction: bus_req and bus_addr hold steady until bus_ack, then bus_req drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| instr_valid | input | 1 | One-cycle strobe that hands over an instruction |
| instr | input | 26 | Bits 25:0 of the coprocessor instruction |
| pc | input | 32 | Address of the instruction |
| gpr_rt_val | input | 32 | Low word of GPR rt, for write moves |
| cop2_en | input | 1 | Coprocessor-2 usable bit of the host status |
| vu_busy | input | 1 | Vector unit busy flag (bit 0 of its status word) |
| bus_ack | input | 1 | Bus acknowledge |
| bus_rdata | input | 32 | Bus read data, valid with bus_ack |
| bus_req | output | 1 | Bus request |
| bus_we | output | 1 | Bus write enable |
| bus_addr | output | 32 | Bus address |
| bus_wdata | output | 32 | Bus write data |
| gpr_we | output | 1 | GPR write strobe |
| gpr_waddr | output | 5 | GPR index to write |
| gpr_wdata | output | 64 | GPR write data |
| br_taken | output | 1 | Branch taken |
| br_target | output | 32 | Branch target |
| nullify | output | 1 | Cancel the delay-slot instruction |
| stall | output | 1 | Waiting on the interlock |
| done | output | 1 | Instruction complete |
| exc | output | 2 | One-hot exception pulse: 01 unusable, 10 reserved |

## Verification
Branch results and exceptions appear on the outputs one clock edge after the edge that samples instr_valid. Moves differ: bus_req rises one edge after acceptance, or one edge after vu_busy falls when the interlock holds it back. Done and the GPR write then follow one edge after the edge that sees bus_ack. The bench drives inputs on the falling edge and samples at the next falling edge after the edge in question. It also counts acknowledged transactions on rising edges, to confirm that each move makes exactly one.

// File: rtl/vcop_decoder.sv
module vcop_decoder #(
  parameter int          AW        = 32,
  parameter int          GPR_W     = 64,
  parameter logic [31:0] CTRL_BASE = 32'h0000_4000,
  parameter logic [31:0] VREG_BASE = 32'h0000_4400
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            instr_valid,
  input  logic [25:0]     instr,
  input  logic [AW-1:0]   pc,
  input  logic [31:0]     gpr_rt_val,
  input  logic            cop2_en,
  input  logic            vu_busy,
  input  logic            bus_ack,
  input  logic [31:0]     bus_rdata,
  output logic            bus_req,
  output logic            bus_we,
  output logic [AW-1:0]   bus_addr,
  output logic [31:0]     bus_wdata,
  output logic            gpr_we,
  output logic [4:0]      gpr_waddr,
  output logic [GPR_W-1:0] gpr_wdata,
  output logic            br_taken,
  output logic [AW-1:0]   br_target,
  output logic            nullify,
  output logic            stall,
  output logic            done,
  output logic [1:0]      exc
);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_BUS} st_t;
  st_t st;

  logic [4:0] fmt, rt, id;
  logic [15:0] imm;
  logic accept, is_br, is_cm, is_vm, take;
  logic [AW-1:0] maddr, boff;

  assign fmt = instr[25:21];
  assign rt  = instr[20:16];
  assign id  = instr[15:11];
  assign imm = instr[15:0];

  assign accept = instr_valid && (st == S_IDLE);
  assign is_br  = (fmt == 5'h08) && (rt[4:2] == 3'd0);
  assign is_cm  = ((fmt == 5'h02) || (fmt == 5'h06)) && (instr[10:1] == 10'd0);
  assign is_vm  = (fmt == 5'h01) || (fmt == 5'h05);
  assign take   = rt[0] ? vu_busy : !vu_busy;
  assign maddr  = (is_cm ? CTRL_BASE[AW-1:0] : VREG_BASE[AW-1:0]) + AW'({id, 4'b0000});
  assign boff   = AW'({{(AW-18){imm[15]}}, imm, 2'b00});

  assign bus_req = (st == S_BUS);
  assign stall   = (st == S_WAIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      done      <= 1'b0;
      exc       <= 2'b00;
      br_taken  <= 1'b0;
      nullify   <= 1'b0;
      br_target <= '0;
      gpr_we    <= 1'b0;
      gpr_waddr <= '0;
      gpr_wdata <= '0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else begin
      done     <= 1'b0;
      exc      <= 2'b00;
      br_taken <= 1'b0;
      nullify  <= 1'b0;
      gpr_we   <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          if (!cop2_en) begin
            exc  <= 2'b01;
            done <= 1'b1;
          end else if (is_br) begin
            done      <= 1'b1;
            br_taken  <= take;
            nullify   <= rt[1] && !take;
            br_target <= pc + AW'(4) + boff;
          end else if (is_cm || is_vm) begin
            bus_addr  <= maddr;
            bus_we    <= fmt[2];
            bus_wdata <= gpr_rt_val;
            gpr_waddr <= rt;
            st        <= (instr[0] && vu_busy) ? S_WAIT : S_BUS;
          end else begin
            exc  <= 2'b10;
            done <= 1'b1;
          end
        end
        S_WAIT: if (!vu_busy) st <= S_BUS;
        S_BUS: if (bus_ack) begin
          st   <= S_IDLE;
          done <= 1'b1;
          if (!bus_we) begin
            gpr_we    <= 1'b1;
            gpr_wdata <= {{(GPR_W-32){bus_rdata[31]}}, bus_rdata};
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R2 R10
  exc_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(exc));

  // R10
  exc_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc != 2'b00) |-> (!bus_req && !gpr_we && !br_taken && done));

  // R8
  stall_noreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !bus_req);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && vu_busy) |=> stall);

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));

  // R11
  req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_ack) |=> (!bus_req && done));

  // R9
  gpr_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gpr_we |-> done);

  // R5
  nullify_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nullify |-> (done && !br_taken));

endmodule

// File: tb/tb_vcop_decoder.sv
module tb_vcop_decoder;
  logic clk = 1'b0, rst_n = 1'b0;
  logic instr_valid = 1'b0;
  logic [25:0] instr = '0;
  logic [31:0] pc = 32'h0000_1000, gpr_rt_val = '0, bus_rdata = '0;
  logic cop2_en = 1'b1, vu_busy = 1'b0, bus_ack = 1'b0;
  logic bus_req, bus_we, gpr_we, br_taken, nullify, stall, done;
  logic [31:0] bus_addr, bus_wdata, br_target;
  logic [4:0] gpr_waddr;
  logic [63:0] gpr_wdata;
  logic [1:0] exc;

  int checks = 0, errors = 0, nbus = 0;

  vcop_decoder dut (.*);

  always #4 clk = ~clk;
  always @(posedge clk) if (bus_req && bus_ack) nbus++;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [25:0] enc(logic [4:0] f, logic [4:0] r, logic [4:0] i, logic [10:0] lo);
    return {f, r, i, lo};
  endfunction

  task automatic issue(logic [25:0] w);
    @(negedge clk);
    instr = w; instr_valid = 1'b1;
    @(negedge clk);
    instr_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 done", done, 0); chk("R1 bus_req", bus_req, 0);
    chk("R1 stall", stall, 0); chk("R1 gpr_we", gpr_we, 0);
    chk("R1 exc", exc, 0); chk("R1 br/nullify", {br_taken, nullify}, 0);
  endtask

  task automatic t_unusable(logic [25:0] w);
    cop2_en = 1'b0;
    issue(w);
    chk("R2 exc", exc, 2'b01); chk("R2 done", done, 1);
    chk("R2 side effects", {bus_req, gpr_we, br_taken, stall}, 0);
    @(negedge clk);
    chk("R2 no later request", {bus_req, stall, exc}, 0);
    cop2_en = 1'b1;
  endtask

  task automatic t_branch(logic [1:0] c, logic busy, logic [15:0] imm);
    logic tk;
    logic [31:0] tgt;
    tk  = c[0] ? busy : !busy;
    tgt = pc + 32'd4 + {{14{imm[15]}}, imm, 2'b00};
    vu_busy = busy;
    @(negedge clk);
    instr = {5'h08, 3'b000, c, imm}; instr_valid = 1'b1;
    @(negedge clk);
    instr_valid = 1'b0; vu_busy = 1'b0;
    chk("R3 taken", br_taken, tk);
    chk("R4 target", br_target, tgt);
    chk("R5 nullify", nullify, c[1] && !tk);
    chk("R3 done", {done, exc}, 3'b100);
  endtask

  task automatic t_move(logic [4:0] f, logic [4:0] r, logic [4:0] i, logic ilk,
                        int busy_cycles, logic [31:0] rval, logic [31:0] rd);
    logic [31:0] a;
    int n0;
    logic wr;
    wr = f[2];
    a  = ((f == 5'h02 || f == 5'h06) ? 32'h0000_4000 : 32'h0000_4400) + {i, 4'b0};
    n0 = nbus;
    gpr_rt_val = rval;
    vu_busy = (busy_cycles > 0);
    issue(enc(f, r, i, {10'd0, ilk}));
    if (ilk && busy_cycles > 0) begin
      for (int k = 0; k < busy_cycles; k++) begin
        chk("R8 stall high", stall, 1); chk("R8 no req", bus_req, 0);
        @(negedge clk);
      end
      vu_busy = 1'b0;
      @(negedge clk);
    end
    chk("R8 stall low", stall, 0);
    chk("R11 req", bus_req, 1);
    chk(f[1] || f == 5'h06 ? "R6 addr" : "R7 addr", bus_addr, a);
    chk("R9 we", bus_we, wr);
    if (wr) chk("R9 wdata", bus_wdata, rval);
    @(negedge clk);
    chk("R11 req held", bus_req, 1); chk("R11 addr held", bus_addr, a);
    bus_ack = 1'b1; bus_rdata = rd;
    @(negedge clk);
    bus_ack = 1'b0; vu_busy = 1'b0;
    chk("R9 done", done, 1); chk("R11 req dropped", bus_req, 0);
    chk("R9 gpr_we", gpr_we, !wr);
    if (!wr) begin
      chk("R9 waddr", gpr_waddr, r);
      chk("R9 sext", gpr_wdata, {{32{rd[31]}}, rd});
    end
    @(negedge clk);
    chk("R11 one transaction", nbus - n0, 1);
    chk("R9 pulse", {done, gpr_we}, 0);
  endtask

  task automatic t_reserved(logic [25:0] w);
    int n0;
    n0 = nbus;
    issue(w);
    chk("R10 exc", exc, 2'b10); chk("R10 done", done, 1);
    chk("R10 quiet", {bus_req, gpr_we, br_taken, stall}, 0);
    @(negedge clk);
    chk("R10 no bus", nbus - n0, 0); chk("R10 req", bus_req, 0);
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_unusable(enc(5'h08, 5'd0, 5'd0, 11'd0));
    t_unusable(enc(5'h05, 5'd3, 5'd1, 11'd1));
    for (int c = 0; c < 4; c++) begin
      t_branch(c[1:0], 1'b0, 16'h0010);
      t_branch(c[1:0], 1'b1, 16'hFFFE);
    end
    t_move(5'h02, 5'd7, 5'd5, 1'b0, 0, 32'h0, 32'h8000_0001);
    t_move(5'h06, 5'd2, 5'd31, 1'b0, 0, 32'hCAFE_F00D, 32'h0);
    t_move(5'h01, 5'd9, 5'd4, 1'b0, 0, 32'h0, 32'h1234_5678);
    t_move(5'h05, 5'd1, 5'd0, 1'b0, 0, 32'hA5A5_0001, 32'h0);
    t_move(5'h01, 5'd3, 5'd2, 1'b1, 3, 32'h0, 32'hFFFF_FFF0);
    t_move(5'h06, 5'd4, 5'd1, 1'b1, 1, 32'h0BAD_BEEF, 32'h0);
    t_move(5'h02, 5'd6, 5'd3, 1'b0, 2, 32'h0, 32'h7000_0000);
    t_reserved(enc(5'h02, 5'd1, 5'd1, 11'b000_0000_0010));
    t_reserved(enc(5'h06, 5'd1, 5'd1, 11'b100_0000_0000));
    t_reserved(enc(5'h08, 5'd4, 5'd0, 11'd0));
    t_reserved(enc(5'h10, 5'd0, 5'd0, 11'd0));
    t_reserved(enc(5'h00, 5'd0, 5'd0, 11'd0));
    finish_run();
  end
endmodule